// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns one decoded memory operand into a 20-bit physical address. An operand is described by up to three offset terms: a base register value, an index register value and a sign-extended displacement of 8 or 16 bits. Each term can be switched on or off, which covers every offset form. The forms are displacement alone, one register alone, two registers, one register plus a displacement, and two registers plus a displacement. The offset is then added to a 16-bit segment value shifted left by four bit positions. The segment comes from a bank of four segment values. An explicit override picks it when present. Without an override, the base register in use decides: the frame-pointer base selects the stack segment, and any other operand selects the data segment.

Two address sizes are supported. In 16-bit addressing the terms are truncated to 16 bits and their sum wraps inside the 64 KiB segment. In 32-bit addressing the index may be scaled by 1, 2, 4 or 8, and the 32-bit sum must stay at or below 0xFFFF. Two operands are flagged as faults instead of producing an address: a larger sum, and the stack-pointer register used as an index.

The result is registered once, giving one cycle of latency. A three-state output machine records the kind of result held. `ST_IDLE` means no result. `ST_ADDR` means a valid address. `ST_FAULT` means a faulted request. The machine moves to `ST_ADDR` on a clean request and to `ST_FAULT` on a faulting one, from any state. It returns to `ST_IDLE` from any state in a cycle without a request.

Top module: `seg_addr_gen`

## Requirements
- R1: While and directly after reset, `out_valid`, `fault`, `phys_addr`, `out_offset` and `seg_used` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `req_valid` high. Outside `ST_ADDR`, `phys_addr` and `out_offset` read zero, and `seg_used` reads zero in `ST_IDLE`.
- R3: For a clean request, `phys_addr` equals (chosen segment value × 16 + `out_offset`) modulo 2^20.
- R4: The offset is the sum of the enabled terms. The base counts when `use_base`=1 and the index counts when `use_index`=1. `disp_sel`=00 adds no displacement, 01 adds `disp[7:0]` sign-extended, and 1x adds `disp` sign-extended.
- R5: With `addr32`=0, only the low 16 bits of the register values are used, `scale` has no effect, and the offset is the sum modulo 2^16.
- R6: With `addr32`=1, the index value is shifted left by `scale` (0 to 3) before it is added, and the sum is formed modulo 2^32.
- R7: Without an override, the stack segment (code 2) is used when `use_base`=1 and `base_sel`=5 (frame pointer). Otherwise the data segment (code 3) is used.
- R8: When `ovr_valid`=1, `ovr_sel` picks the segment regardless of the base register. `seg_used` reports the code in use: 0 is `seg_es`, 1 is `seg_cs`, 2 is `seg_ss` and 3 is `seg_ds`.
- R9: With `addr32`=1, a 32-bit offset sum above 0x0000FFFF gives `fault`=1 with `out_valid`=1 and `phys_addr`=0.
- R10: With `addr32`=1, `use_index`=1 and `index_sel`=4 (stack pointer) gives `fault`=1 and `phys_addr`=0. With `addr32`=0 the same selection is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operand present this cycle |
| addr32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| use_base | input | 1 | Base term enabled |
| base_sel | input | 3 | Base register number (5 = frame pointer) |
| base_val | input | 32 | Base register value |
| use_index | input | 1 | Index term enabled |
| index_sel | input | 3 | Index register number (4 = stack pointer) |
| index_val | input | 32 | Index register value |
| scale | input | 2 | Index shift amount in 32-bit addressing |
| disp_sel | input | 2 | Displacement size: 00 none, 01 byte, 1x word |
| disp | input | 16 | Displacement value |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| seg_es | input | 16 | Extra segment value (code 0) |
| seg_cs | input | 16 | Code segment value (code 1) |
| seg_ss | input | 16 | Stack segment value (code 2) |
| seg_ds | input | 16 | Data segment value (code 3) |
| out_valid | output | 1 | Registered result present |
| fault | output | 1 | Result is a fault |
| phys_addr | output | 20 | Physical address |
| out_offset | output | 16 | Offset within the segment |
| seg_used | output | 2 | Segment code used |

## Verification
The properties assume that every input is a known value at each rising edge while reset is released. They also assume that the four segment values seen at the edge that captures a request are the ones the address was built from. The bench meets both assumptions. It drives every input from one task on the falling edge and holds it through the following rising edge. It never leaves any input unknown, including the register values of terms that are switched off. The random 32-bit operands are kept small enough that clean and faulting sums both occur.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    typedef enum logic [1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_code_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_FAULT = 2'd2
    } out_state_e;

    localparam int unsigned REG_SEL_W = 3;
    localparam logic [REG_SEL_W-1:0] REG_STACK_PTR = 3'd4;
    localparam logic [REG_SEL_W-1:0] REG_FRAME_PTR = 3'd5;
    localparam int unsigned SEG_SHIFT = 4;
    localparam int unsigned BYTE_W    = 8;

endpackage

// File: rtl/seg_addr_offset.sv
module seg_addr_offset
    import seg_addr_pkg::*;
#(
    parameter int unsigned WIDE_W  = 32,
    parameter int unsigned OFF_W   = 16,
    parameter int unsigned DISP_W  = 16,
    parameter int unsigned SCALE_W = 2
) (
    input  logic                 addr32,
    input  logic                 use_base,
    input  logic [WIDE_W-1:0]    base_val,
    input  logic                 use_index,
    input  logic [REG_SEL_W-1:0] index_sel,
    input  logic [WIDE_W-1:0]    index_val,
    input  logic [SCALE_W-1:0]   scale,
    input  logic [1:0]           disp_sel,
    input  logic [DISP_W-1:0]    disp,
    output logic [OFF_W-1:0]     offset,
    output logic                 range_fault,
    output logic                 sp_index_fault
);

    localparam int unsigned HI_W = WIDE_W - OFF_W;

    logic [WIDE_W-1:0] base_term;
    logic [WIDE_W-1:0] index_term;
    logic [WIDE_W-1:0] disp_term;
    logic [WIDE_W-1:0] sum_w;

    always_comb begin
        base_term  = use_base ? base_val : '0;
        index_term = '0;
        if (use_index) begin
            index_term = addr32 ? (index_val << scale) : index_val;
        end
        unique case (disp_sel)
            2'b00:   disp_term = '0;
            2'b01:   disp_term = {{(WIDE_W-BYTE_W){disp[BYTE_W-1]}}, disp[BYTE_W-1:0]};
            default: disp_term = {{(WIDE_W-DISP_W){disp[DISP_W-1]}}, disp};
        endcase
        sum_w = base_term + index_term + disp_term;
    end

    // In 16-bit addressing the low bits of the wide sum are the wrapped sum.
    assign offset         = sum_w[OFF_W-1:0];
    assign range_fault    = addr32 && (sum_w[WIDE_W-1 -: HI_W] != '0);
    assign sp_index_fault = addr32 && use_index && (index_sel == REG_STACK_PTR);

endmodule

// File: rtl/seg_addr_segsel.sv
module seg_addr_segsel
    import seg_addr_pkg::*;
#(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned N_SEG = 4
) (
    input  logic                       ovr_valid,
    input  logic [$clog2(N_SEG)-1:0]   ovr_sel,
    input  logic                       use_base,
    input  logic [REG_SEL_W-1:0]       base_sel,
    input  logic [N_SEG-1:0][SEG_W-1:0] seg_bank,
    output logic [$clog2(N_SEG)-1:0]   seg_code,
    output logic [SEG_W-1:0]           seg_val
);

    localparam int unsigned CODE_W = $clog2(N_SEG);

    logic [CODE_W-1:0] default_code;

    always_comb begin
        if (use_base && base_sel == REG_FRAME_PTR) begin
            default_code = CODE_W'(SEG_STACK);
        end else begin
            default_code = CODE_W'(SEG_DATA);
        end
        seg_code = ovr_valid ? ovr_sel : default_code;
    end

    always_comb begin
        seg_val = '0;
        for (int k = 0; k < N_SEG; k++) begin
            if (seg_code == CODE_W'(k)) seg_val = seg_bank[k];
        end
    end

endmodule

// File: rtl/seg_addr_phys.sv
module seg_addr_phys
    import seg_addr_pkg::*;
#(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFF_W = 16
) (
    input  logic [SEG_W-1:0]           seg_val,
    input  logic [OFF_W-1:0]           offset,
    output logic [SEG_W+SEG_SHIFT-1:0] phys
);

    localparam int unsigned PHYS_W = SEG_W + SEG_SHIFT;

    assign phys = {seg_val, {SEG_SHIFT{1'b0}}} + PHYS_W'(offset);

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int unsigned WIDE_W  = 32,
    parameter int unsigned OFF_W   = 16,
    parameter int unsigned DISP_W  = 16,
    parameter int unsigned SEG_W   = 16,
    parameter int unsigned SCALE_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       addr32,
    input  logic                       use_base,
    input  logic [2:0]                 base_sel,
    input  logic [WIDE_W-1:0]          base_val,
    input  logic                       use_index,
    input  logic [2:0]                 index_sel,
    input  logic [WIDE_W-1:0]          index_val,
    input  logic [SCALE_W-1:0]         scale,
    input  logic [1:0]                 disp_sel,
    input  logic [DISP_W-1:0]          disp,
    input  logic                       ovr_valid,
    input  logic [1:0]                 ovr_sel,
    input  logic [SEG_W-1:0]           seg_es,
    input  logic [SEG_W-1:0]           seg_cs,
    input  logic [SEG_W-1:0]           seg_ss,
    input  logic [SEG_W-1:0]           seg_ds,
    output logic                       out_valid,
    output logic                       fault,
    output logic [SEG_W+SEG_SHIFT-1:0] phys_addr,
    output logic [OFF_W-1:0]           out_offset,
    output logic [1:0]                 seg_used
);

    localparam int unsigned PHYS_W = SEG_W + SEG_SHIFT;
    localparam int unsigned N_SEG  = 4;

    logic [N_SEG-1:0][SEG_W-1:0] seg_bank;
    logic [OFF_W-1:0]  off_c;
    logic              range_fault_c;
    logic              sp_fault_c;
    logic              fault_c;
    logic [1:0]        seg_code_c;
    logic [SEG_W-1:0]  seg_val_c;
    logic [PHYS_W-1:0] phys_c;

    out_state_e        state_q, state_d;
    logic [PHYS_W-1:0] phys_q;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        seg_q;

    assign seg_bank = {seg_ds, seg_ss, seg_cs, seg_es};

    seg_addr_offset #(
        .WIDE_W(WIDE_W), .OFF_W(OFF_W), .DISP_W(DISP_W), .SCALE_W(SCALE_W)
    ) u_offset (
        .addr32        (addr32),
        .use_base      (use_base),
        .base_val      (base_val),
        .use_index     (use_index),
        .index_sel     (index_sel),
        .index_val     (index_val),
        .scale         (scale),
        .disp_sel      (disp_sel),
        .disp          (disp),
        .offset        (off_c),
        .range_fault   (range_fault_c),
        .sp_index_fault(sp_fault_c)
    );

    seg_addr_segsel #(.SEG_W(SEG_W), .N_SEG(N_SEG)) u_segsel (
        .ovr_valid(ovr_valid),
        .ovr_sel  (ovr_sel),
        .use_base (use_base),
        .base_sel (base_sel),
        .seg_bank (seg_bank),
        .seg_code (seg_code_c),
        .seg_val  (seg_val_c)
    );

    seg_addr_phys #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_phys (
        .seg_val(seg_val_c),
        .offset (off_c),
        .phys   (phys_c)
    );

    assign fault_c = range_fault_c || sp_fault_c;

    // Next-state logic: every state reacts the same way to the request.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ADDR, ST_FAULT: begin
                if (!req_valid)   state_d = ST_IDLE;
                else if (fault_c) state_d = ST_FAULT;
                else              state_d = ST_ADDR;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phys_q  <= '0;
            off_q   <= '0;
            seg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                phys_q <= phys_c;
                off_q  <= off_c;
                seg_q  <= seg_code_c;
            end
        end
    end

    always_comb begin
        out_valid  = 1'b0;
        fault      = 1'b0;
        phys_addr  = '0;
        out_offset = '0;
        seg_used   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ADDR: begin
                out_valid  = 1'b1;
                phys_addr  = phys_q;
                out_offset = off_q;
                seg_used   = seg_q;
            end
            ST_FAULT: begin
                out_valid = 1'b1;
                fault     = 1'b1;
                seg_used  = seg_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        addr32,
    input logic        use_base,
    input logic [2:0]  base_sel,
    input logic        use_index,
    input logic [2:0]  index_sel,
    input logic        ovr_valid,
    input logic [1:0]  ovr_sel,
    input logic [15:0] seg_es,
    input logic [15:0] seg_cs,
    input logic [15:0] seg_ss,
    input logic [15:0] seg_ds,
    input logic        out_valid,
    input logic        fault,
    input logic [19:0] phys_addr,
    input logic [15:0] out_offset,
    input logic [1:0]  seg_used
);

    logic [15:0] es_q, cs_q, ss_q, ds_q;
    logic [15:0] picked;

    always_ff @(posedge clk) begin
        es_q <= seg_es;
        cs_q <= seg_cs;
        ss_q <= seg_ss;
        ds_q <= seg_ds;
    end

    always_comb begin
        unique case (seg_used)
            2'd0:    picked = es_q;
            2'd1:    picked = cs_q;
            2'd2:    picked = ss_q;
            default: picked = ds_q;
        endcase
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    assert_fault_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> out_valid);
    assert_phys_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !fault) |-> phys_addr == 20'({picked, 4'b0000} + {4'b0000, out_offset}));
    assert_fault_no_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> phys_addr == 20'd0);
    assert_override_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ovr_valid) |=> seg_used == $past(ovr_sel));
    assert_frame_stack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ovr_valid && use_base && base_sel == 3'd5) |=> seg_used == 2'd2);
    assert_sp_index_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && addr32 && use_index && index_sel == 3'd4) |=> fault);

endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr32(addr32),
    .use_base(use_base), .base_sel(base_sel), .use_index(use_index),
    .index_sel(index_sel), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .out_valid(out_valid), .fault(fault), .phys_addr(phys_addr),
    .out_offset(out_offset), .seg_used(seg_used)
);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        addr32 = 1'b0;
    logic        use_base = 1'b0;
    logic [2:0]  base_sel = 3'd0;
    logic [31:0] base_val = 32'd0;
    logic        use_index = 1'b0;
    logic [2:0]  index_sel = 3'd0;
    logic [31:0] index_val = 32'd0;
    logic [1:0]  scale = 2'd0;
    logic [1:0]  disp_sel = 2'd0;
    logic [15:0] disp = 16'd0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_sel = 2'd0;
    logic [15:0] seg_es = 16'h0000, seg_cs = 16'h0000, seg_ss = 16'h0000, seg_ds = 16'h0000;
    logic        out_valid, fault;
    logic [19:0] phys_addr;
    logic [15:0] out_offset;
    logic [1:0]  seg_used;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seg_addr_gen u_seg_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr32(addr32),
        .use_base(use_base), .base_sel(base_sel), .base_val(base_val),
        .use_index(use_index), .index_sel(index_sel), .index_val(index_val),
        .scale(scale), .disp_sel(disp_sel), .disp(disp),
        .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .out_valid(out_valid), .fault(fault), .phys_addr(phys_addr),
        .out_offset(out_offset), .seg_used(seg_used)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: returns the expected registered outputs.
    task automatic model(output bit v, output bit f, output longint ph,
                         output longint off, output longint sg);
        longint b, i, d, s, segv;
        if (addr32) begin
            b = use_base ? longint'(base_val) : 0;
            i = use_index ? (longint'(index_val) << scale) : 0;
        end else begin
            b = use_base ? longint'(base_val[15:0]) : 0;
            i = use_index ? longint'(index_val[15:0]) : 0;
        end
        if (disp_sel == 2'b00)      d = 0;
        else if (disp_sel == 2'b01) d = longint'($signed(disp[7:0]));
        else                        d = longint'($signed(disp));
        s = b + i + d;
        s = addr32 ? (s & 64'hFFFF_FFFF) : (s & 64'hFFFF);
        f = addr32 && ((use_index && index_sel == 3'd4) || s > 65535);
        if (ovr_valid) sg = ovr_sel;
        else if (use_base && base_sel == 3'd5) sg = 2;
        else sg = 3;
        case (sg)
            0: segv = seg_es;
            1: segv = seg_cs;
            2: segv = seg_ss;
            default: segv = seg_ds;
        endcase
        v = req_valid;
        ph = ((segv * 16) + s) & 64'hF_FFFF;
        off = s;
        if (!v) begin ph = 0; off = 0; sg = 0; f = 0; end
        else if (f) begin ph = 0; off = 0; end
    endtask

    // Inputs are already set; predict, cross one rising edge, compare on the falling edge.
    task automatic step(input string req);
        bit ev, ef;
        longint eph, eoff, esg;
        model(ev, ef, eph, eoff, esg);
        @(negedge clk);
        check(req, "out_valid", longint'(out_valid), longint'(ev));
        check(req, "fault", longint'(fault), longint'(ef));
        check(req, "phys_addr", longint'(phys_addr), eph);
        check(req, "out_offset", longint'(out_offset), eoff);
        check(req, "seg_used", longint'(seg_used), esg);
    endtask

    task automatic op(input bit a32, input bit ub, input logic [2:0] bs, input logic [31:0] bv,
                      input bit ui, input logic [2:0] is, input logic [31:0] iv,
                      input logic [1:0] sc, input logic [1:0] ds, input logic [15:0] dv,
                      input bit ov, input logic [1:0] os, input string req);
        req_valid = 1'b1; addr32 = a32; use_base = ub; base_sel = bs; base_val = bv;
        use_index = ui; index_sel = is; index_val = iv; scale = sc;
        disp_sel = ds; disp = dv; ovr_valid = ov; ovr_sel = os;
        step(req);
    endtask

    task automatic idle(input string req);
        req_valid = 1'b0;
        step(req);
    endtask

    initial begin
        seg_es = 16'h3000; seg_cs = 16'h4000; seg_ss = 16'h0100; seg_ds = 16'h1000;
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", longint'(out_valid), 0);
        check("R1", "phys_addr in reset", longint'(phys_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", longint'(out_valid), 0);
        check("R1", "seg_used after reset", longint'(seg_used), 0);

        // R4 offset forms, R3 address, R7 data segment default
        op(0, 0, 3'd3, 32'h0, 0, 3'd6, 32'h0, 2'd0, 2'b10, 16'h1234, 0, 2'd0, "R4_disp_only");
        op(0, 1, 3'd3, 32'h1000, 0, 3'd6, 32'h0, 2'd0, 2'b00, 16'h0, 0, 2'd0, "R4_base_only");
        op(0, 1, 3'd3, 32'h0100, 1, 3'd7, 32'h0010, 2'd0, 2'b00, 16'h0, 0, 2'd0, "R4_base_index");
        op(0, 0, 3'd3, 32'h0, 1, 3'd7, 32'h0200, 2'd0, 2'b01, 16'h00F0, 0, 2'd0, "R4_index_neg_byte");
        op(0, 1, 3'd3, 32'h0100, 1, 3'd6, 32'h0020, 2'd0, 2'b11, 16'h1000, 0, 2'd0, "R4_all_three");
        idle("R2_gap");
        // R5 16-bit wrap, scale ignored, upper bits ignored
        op(0, 1, 3'd3, 32'hABCD_FFF0, 0, 3'd6, 32'h0, 2'd0, 2'b01, 16'h0020, 0, 2'd0, "R5_wrap16");
        op(0, 0, 3'd3, 32'h0, 1, 3'd6, 32'h0000_0100, 2'd3, 2'b00, 16'h0, 0, 2'd0, "R5_scale_ignored");
        op(0, 0, 3'd3, 32'h0, 1, 3'd4, 32'h0000_0040, 2'd0, 2'b00, 16'h0, 0, 2'd0, "R10_sp_ok_16bit");
        // R6 scaling
        for (int k = 0; k < 4; k++)
            op(1, 1, 3'd3, 32'h100, 1, 3'd6, 32'h300, 2'(k), 2'b00, 16'h0, 0, 2'd0, "R6_scale");
        // R7 frame pointer base uses stack segment
        op(1, 1, 3'd5, 32'h0040, 1, 3'd6, 32'h2, 2'd1, 2'b01, 16'h0004, 0, 2'd0, "R7_frame_stack");
        op(0, 0, 3'd5, 32'h0040, 1, 3'd5, 32'h8, 2'd0, 2'b00, 16'h0, 0, 2'd0, "R7_fp_as_index_data");
        // R8 overrides
        for (int k = 0; k < 4; k++)
            op(0, 1, 3'd5, 32'h0040, 0, 3'd6, 32'h0, 2'd0, 2'b00, 16'h0, 1, 2'(k), "R8_override");
        // R3 physical wrap above 1 MiB
        seg_ds = 16'hFFFF;
        op(0, 0, 3'd3, 32'h0, 0, 3'd6, 32'h0, 2'd0, 2'b10, 16'h0020, 0, 2'd0, "R3_phys_wrap");
        seg_ds = 16'h1000;
        // R9 range fault, boundary just inside
        op(1, 1, 3'd3, 32'h0000_FFFF, 0, 3'd6, 32'h0, 2'd0, 2'b00, 16'h0, 0, 2'd0, "R9_edge_ok");
        op(1, 1, 3'd3, 32'h0000_FFFF, 0, 3'd6, 32'h0, 2'd0, 2'b01, 16'h0001, 0, 2'd0, "R9_over");
        op(1, 0, 3'd3, 32'h0, 1, 3'd6, 32'h4000, 2'd2, 2'b00, 16'h0, 0, 2'd0, "R9_scaled_over");
        op(1, 1, 3'd3, 32'h0000_0010, 0, 3'd6, 32'h0, 2'd0, 2'b11, 16'h8000, 0, 2'd0, "R9_negative_wrap");
        // R10 stack pointer index in 32-bit addressing
        op(1, 1, 3'd3, 32'h10, 1, 3'd4, 32'h0, 2'd0, 2'b00, 16'h0, 0, 2'd0, "R10_sp_index");
        op(1, 1, 3'd4, 32'h10, 0, 3'd4, 32'h0, 2'd0, 2'b00, 16'h0, 0, 2'd0, "R10_sp_base_ok");
        idle("R2_after_fault");

        // Mixed random stream, with idle cycles (R2..R10)
        for (int n = 0; n < 400; n++) begin
            seg_es = 16'($urandom); seg_cs = 16'($urandom);
            seg_ss = 16'($urandom); seg_ds = 16'($urandom);
            req_valid = ($urandom_range(0, 4) != 0);
            addr32 = 1'($urandom);
            use_base = 1'($urandom); base_sel = 3'($urandom);
            use_index = 1'($urandom); index_sel = 3'($urandom);
            base_val  = addr32 ? 32'($urandom_range(0, 70000)) : $urandom;
            index_val = addr32 ? 32'($urandom_range(0, 12000)) : $urandom;
            scale = 2'($urandom); disp_sel = 2'($urandom); disp = 16'($urandom);
            ovr_valid = ($urandom_range(0, 3) == 0); ovr_sel = 2'($urandom);
            step("R2_R10_random");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule